// File: doc/BRIEF.md
# Start-up Delay Sequencer

This block decides when a processor core may start running. After power-on, and after an external reset request goes away, it keeps the core in reset. It first counts a short fixed settle period of six main-clock cycles. It then counts an optional long time-out, which gives the supply and the oscillator time to become stable. The length of the time-out comes from a 2-bit start-up select code.

When the core is woken from a deep sleep state, the clock is assumed to be already stable. The core is held halted, not in reset, for the six-cycle settle period only, whatever the select code is.

All counting runs on the main clock. The millisecond time-outs are built from a cycles-per-millisecond parameter, so a bench can use a small value and still check every count exactly. Select code 11 has no defined meaning. The block treats it as the slowest setting and raises a sticky error flag.

Top module: `startup_seq`

## Requirements
- R1: While `por_n` is low, the outputs are `core_reset`=1, `busy`=1, `core_run`=0 and `config_error`=0. This takes effect at once, without waiting for a clock edge.
- R2: For every clock edge at which `ext_rst_req` is sampled high, `core_reset` and `busy` are 1 after that edge. They stay 1 for as long as the request is held.
- R3: Let edge k be the first edge at which the reset is released: `por_n` is high and `ext_rst_req` is sampled low. With `startup_sel`=00 (no extra time-out), `core_run` goes high at edge k+6, and `core_reset` drops at that same edge.
- R4: With `startup_sel`=01 (fast supply), the release edge is k+6+floor(41*CYC_PER_MS/10). This is about 4.1 ms.
- R5: With `startup_sel`=10 (slow supply), the release edge is k+6+65*CYC_PER_MS. This is about 65 ms.
- R6: With `startup_sel`=11 (reserved), the timing is the same as for code 10. `config_error` is set from edge k onward. It stays set through later resets caused by `ext_rst_req`, and only `por_n` low clears it.
- R7: Consider a `wake_req` sampled at edge k while the block is idle (`busy`=0) and no reset is requested. Then `busy` is 1 from edge k, `core_reset` stays 0, and `core_run` goes high at edge k+6. This holds for every select code.
- R8: If `ext_rst_req` rises while a delay is being counted, the count is abandoned. The full sequence (6 cycles plus the time-out) then restarts from the next release.
- R9: `core_run` is high for exactly one cycle. `busy` stays high from the trigger up to and including that cycle. If no new reset is requested, `busy` is 0 in the next cycle.
- R10: A `wake_req` that arrives while `busy` is 1 is ignored. It produces no extra `core_run` pulse and leaves `busy` at 0 once the current sequence ends.
- R11: The select code is captured at the release edge k. If `startup_sel` changes while the delay is being counted, the delay in progress does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock; all delay counting uses it |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| ext_rst_req | input | 1 | External reset request, level sensitive, active high |
| wake_req | input | 1 | Wake request from deep sleep, sampled while idle |
| startup_sel | input | 2 | Start-up select code: 00 none, 01 fast, 10 slow, 11 reserved |
| core_reset | output | 1 | Holds the core in reset |
| core_run | output | 1 | One-cycle pulse when the core is released |
| busy | output | 1 | High while a hold or delay sequence is in progress |
| config_error | output | 1 | Sticky flag: reserved select code was used |

## Verification
The hardest case to reach from the ports is a new reset arriving in the middle of a long time-out. The bench releases a fast-supply reset, waits part way into the count, and raises the request again. It then checks the single release pulse against a count that starts from the second release, so any pulse left over from the first sequence is reported. The same kind of mid-count stimulus is used to check R10 and R11: a wake pulse is injected during the delay, and the select code is switched right after the release. In both cases the single release pulse must come out unchanged.

// File: rtl/startup_pkg.sv
package startup_pkg;

    typedef enum logic [2:0] {
        ST_HOLD = 3'd0,
        ST_FIX  = 3'd1,
        ST_LONG = 3'd2,
        ST_DONE = 3'd3,
        ST_IDLE = 3'd4
    } seq_st_e;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_FAST = 2'b01,
        SEL_SLOW = 2'b10,
        SEL_RSVD = 2'b11
    } start_sel_e;

    // Long time-out in cycles for a select code
    function automatic int unsigned long_cycles(input start_sel_e sel,
                                                input int unsigned cpm);
        case (sel)
            SEL_NONE: long_cycles = 0;
            SEL_FAST: long_cycles = (cpm * 41) / 10;
            default:  long_cycles = cpm * 65;
        endcase
    endfunction

endpackage

// File: rtl/startup_code_dec.sv
module startup_code_dec
    import startup_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 8000,
    parameter int unsigned CW         = 20
) (
    input  logic [1:0]    sel,
    output logic [CW-1:0] long_cyc,
    output logic          reserved
);
    localparam int unsigned L_FAST = long_cycles(SEL_FAST, CYC_PER_MS);
    localparam int unsigned L_SLOW = long_cycles(SEL_SLOW, CYC_PER_MS);

    always_comb begin
        reserved = 1'b0;
        case (start_sel_e'(sel))
            SEL_NONE: long_cyc = '0;
            SEL_FAST: long_cyc = CW'(L_FAST);
            SEL_SLOW: long_cyc = CW'(L_SLOW);
            default: begin
                long_cyc = CW'(L_SLOW);
                reserved = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/startup_ctrl.sv
module startup_ctrl
    import startup_pkg::*;
#(
    parameter int unsigned FIX_CYC = 6,
    parameter int unsigned CW      = 20
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          ext_rst_req,
    input  logic          wake_req,
    input  logic [CW-1:0] long_cyc,
    input  logic          code_reserved,
    output logic          core_reset,
    output logic          core_run,
    output logic          busy,
    output logic          config_error
);
    localparam logic [CW-1:0] FIX_LAST = CW'(FIX_CYC - 1);
    localparam logic [CW-1:0] ONE      = CW'(1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          rst_path;
        logic          cfg_err;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            ST_HOLD: begin
                if (!ext_rst_req) begin
                    d.st  = ST_FIX;
                    d.cnt = '0;
                    d.lim = long_cyc;
                    if (code_reserved) d.cfg_err = 1'b1;
                end
            end
            ST_FIX: begin
                if (q.cnt == FIX_LAST) begin
                    d.cnt = '0;
                    d.st  = (q.lim == '0) ? ST_DONE : ST_LONG;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_LONG: begin
                if (q.cnt == q.lim - ONE) begin
                    d.cnt = '0;
                    d.st  = ST_DONE;
                end else begin
                    d.cnt = q.cnt + ONE;
                end
            end
            ST_DONE: d.st = ST_IDLE;
            ST_IDLE: begin
                if (wake_req) begin
                    d.st       = ST_FIX;
                    d.cnt      = '0;
                    d.lim      = '0;
                    d.rst_path = 1'b0;
                end
            end
            default: d.st = ST_HOLD;
        endcase
        // a reset request overrides any sequence in progress
        if (ext_rst_req) begin
            d.st       = ST_HOLD;
            d.cnt      = '0;
            d.rst_path = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            q.st       <= ST_HOLD;
            q.cnt      <= '0;
            q.lim      <= '0;
            q.rst_path <= 1'b1;
            q.cfg_err  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign core_run     = (q.st == ST_DONE);
    assign busy         = (q.st != ST_IDLE);
    assign core_reset   = q.rst_path && (q.st != ST_DONE) && (q.st != ST_IDLE);
    assign config_error = q.cfg_err;
endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_pkg::*;
#(
    parameter int unsigned CYC_PER_MS = 8000,
    parameter int unsigned FIX_CYC    = 6
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       ext_rst_req,
    input  logic       wake_req,
    input  logic [1:0] startup_sel,
    output logic       core_reset,
    output logic       core_run,
    output logic       busy,
    output logic       config_error
);
    localparam int unsigned MAX_CYC = (65 * CYC_PER_MS > FIX_CYC) ? 65 * CYC_PER_MS : FIX_CYC;
    localparam int unsigned CW      = $clog2(MAX_CYC + 1);

    logic [CW-1:0] long_cyc;
    logic          code_reserved;

    startup_code_dec #(
        .CYC_PER_MS(CYC_PER_MS),
        .CW        (CW)
    ) u_dec (
        .sel      (startup_sel),
        .long_cyc (long_cyc),
        .reserved (code_reserved)
    );

    startup_ctrl #(
        .FIX_CYC(FIX_CYC),
        .CW     (CW)
    ) u_ctrl (
        .clk           (clk),
        .por_n         (por_n),
        .ext_rst_req   (ext_rst_req),
        .wake_req      (wake_req),
        .long_cyc      (long_cyc),
        .code_reserved (code_reserved),
        .core_reset    (core_reset),
        .core_run      (core_run),
        .busy          (busy),
        .config_error  (config_error)
    );
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
    input logic clk,
    input logic por_n,
    input logic ext_rst_req,
    input logic wake_req,
    input logic core_reset,
    input logic core_run,
    input logic busy,
    input logic config_error
);
    // R2
    ext_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        ext_rst_req |=> (core_reset && busy));

    // R6
    cfg_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        config_error |=> config_error);

    // R7
    wake_start_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!busy && wake_req && !ext_rst_req) |=> (busy && !core_reset));

    // R9
    run_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        core_run |=> !core_run);

    // R9
    run_busy_end_chk: assert property (@(posedge clk) disable iff (!por_n)
        (core_run && !ext_rst_req) |=> !busy);

    // R9
    run_in_busy_chk: assert property (@(posedge clk) disable iff (!por_n)
        core_run |-> (busy && !core_reset));

    // R10
    wake_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
        (busy && !core_run && !core_reset && !ext_rst_req) |=> !core_reset);
endmodule

bind startup_seq startup_seq_chk u_chk (
    .clk          (clk),
    .por_n        (por_n),
    .ext_rst_req  (ext_rst_req),
    .wake_req     (wake_req),
    .core_reset   (core_reset),
    .core_run     (core_run),
    .busy         (busy),
    .config_error (config_error)
);

// File: tb/sim_startup_seq.sv
module sim_startup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int CPM        = 20;
    localparam int FIXC       = 6;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       ext_rst_req = 1'b0;
    logic       wake_req = 1'b0;
    logic [1:0] startup_sel = 2'b00;
    logic       core_reset, core_run, busy, config_error;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int runs = 0;
    int exp_q[$];
    string tag_q[$];

    startup_seq #(.CYC_PER_MS(CPM), .FIX_CYC(FIXC)) u0 (
        .clk(clk), .por_n(por_n), .ext_rst_req(ext_rst_req), .wake_req(wake_req),
        .startup_sel(startup_sel), .core_reset(core_reset), .core_run(core_run),
        .busy(busy), .config_error(config_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_long(input logic [1:0] code);
        case (code)
            2'b00:   exp_long = 0;
            2'b01:   exp_long = (CPM * 41) / 10;
            default: exp_long = CPM * 65;
        endcase
    endfunction

    // monitor: compare each release pulse against the scoreboard
    always @(negedge clk) begin
        if (por_n && core_run) begin
            runs++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected core_run", cyc, -1);
            end else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(cyc == e, t, cyc, e);
                chk(!core_reset, t, core_reset, 0);
            end
        end
    end

    task automatic push_exp(input int e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !busy) break;
        end
        chk(exp_q.size() == 0 && !busy, "R9 sequence completes", exp_q.size(), 0);
    endtask

    // hold external reset for a few cycles, then release
    task automatic ext_reset(input logic [1:0] code, input string t, input bit expect_run);
        @(negedge clk);
        startup_sel = code;
        ext_rst_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(core_reset && busy && !core_run, "R2 held in reset", {core_reset, busy}, 3);
        end
        ext_rst_req = 1'b0;
        if (expect_run) push_exp(cyc + 1 + FIXC + exp_long(code), t);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int r0;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(core_reset && busy && !core_run && !config_error, "R1 power-on state",
            {core_reset, busy, core_run, config_error}, 4'b1100);
        por_n = 1'b1;
        push_exp(cyc + 1 + FIXC, "R3 release after power-on, code 00");
        wait_idle();

        ext_reset(2'b00, "R3 code 00 release at k+6", 1'b1);
        wait_idle();
        ext_reset(2'b01, "R4 code 01 release at k+6+82", 1'b1);
        wait_idle();
        ext_reset(2'b10, "R5 code 10 release at k+6+1300", 1'b1);
        wait_idle();
        chk(!config_error, "R6 no error for valid codes", config_error, 0);

        ext_reset(2'b11, "R6 code 11 timed like 10", 1'b1);
        @(negedge clk);
        chk(config_error, "R6 error flag raised", config_error, 1);
        wait_idle();
        ext_reset(2'b00, "R6 code 00 after reserved", 1'b1);
        wait_idle();
        chk(config_error, "R6 error flag sticky", config_error, 1);

        // R7 wake from sleep, several codes
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            startup_sel = 2'(c);
            wake_req = 1'b1;
            push_exp(cyc + 1 + FIXC, "R7 wake release at k+6");
            @(negedge clk);
            wake_req = 1'b0;
            chk(busy && !core_reset, "R7 wake halts without reset", {busy, core_reset}, 2);
            wait_idle();
        end

        // R8 restart during long time-out
        ext_reset(2'b01, "R8 first release", 1'b0);
        repeat (30) @(negedge clk);
        chk(!core_run && busy, "R8 counting", core_run, 0);
        ext_reset(2'b01, "R8 restarted full sequence", 1'b1);
        wait_idle();

        // R10 wake during countdown ignored
        r0 = runs;
        ext_reset(2'b01, "R10 reset with wake injected", 1'b1);
        repeat (20) @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        chk(!busy, "R10 wake while busy ignored", busy, 0);
        chk(runs - r0 == 1, "R10 single pulse", runs - r0, 1);

        // R10 wake while reset held ignored
        @(negedge clk);
        startup_sel = 2'b00;
        ext_rst_req = 1'b1;
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
        @(negedge clk);
        ext_rst_req = 1'b0;
        push_exp(cyc + 1 + FIXC, "R10 wake during reset hold");
        wait_idle();

        // R11 code change during count
        ext_reset(2'b10, "R11 code latched at release", 1'b1);
        @(negedge clk);
        startup_sel = 2'b00;
        wait_idle();

        // R1 power-on clears the error flag
        @(negedge clk);
        por_n = 1'b0;
        #1;
        chk(!config_error && core_reset && busy, "R1 por clears error",
            {config_error, core_reset, busy}, 3'b011);
        @(negedge clk);
        por_n = 1'b1;
        push_exp(cyc + 1 + FIXC, "R1 release after second power-on");
        wait_idle();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule